// File: doc/BRIEF.md
# Segmented Dynamic Scan Shift Controller

This block sits between a test decompressor and the scan chains it feeds. The decompressor runs on every clock cycle, but the chains move only when the block raises a one-cycle shift enable. The block can stall the chains for a chosen number of cycles before a shift. During a stall the decompressor keeps advancing and takes in extra free variables from the tester. No extra top-level pin is needed for this.

A scan load is cut into a fixed number of equal-length segments, counted from the scan inputs. Before a pattern, software-free test logic shifts one control bit per segment into the block, one bit per cycle. When a pattern start strobe arrives, the block plays out the load. Every shift in a segment whose bit is set is preceded by a programmable number of stall cycles. Shifts in a segment whose bit is clear run back to back.

The first shifts of a load carry data to the far (output) end of the chains, so they belong to the highest-numbered segment. When the longest chain is shorter than segments × segment length, the first shifts of the load pad the output-end segment and are flagged. One cycle after the final shift, a done pulse is raised.

Top module: `dyn_shift_ctrl`

## Requirements
- R1: While the block is idle and `load_ctrl` is high, one `ctrl_bit` per cycle is shifted into the segment control register, least significant bit first. After NSEG such cycles, the first bit sent controls segment 0. Segment 0 is the one nearest the scan inputs.
- R2: While a load is in progress, `load_ctrl` and `start` are ignored. The control register keeps its value, and the running load is neither restarted nor altered.
- R3: In a segment whose control bit is 0, a shift cycle occurs on every cycle, with no stall cycles between shifts.
- R4: In a segment whose control bit is 1, exactly `halt_n` stall cycles come before every shift cycle of that segment. A stall cycle has `decomp_adv` = 1 and `shift_en` = 0.
- R5: `decomp_adv` is 1 on every cycle of a load, covering both stall and shift cycles. It is 0 while idle and on the done cycle. `shift_en` is never 1 without `decomp_adv`.
- R6: Shift number k of a load (counting from 0) belongs to segment NSEG-1-floor(k/`seg_len`).
- R7: A load has exactly NSEG×`seg_len` shift cycles. It lasts NSEG×`seg_len` + `halt_n`×`seg_len`×(number of set control bits) cycles.
- R8: `pad_shift` is 1 together with `shift_en` on the first NSEG×`seg_len` − `chain_len` shifts of a load, and 0 on every other cycle.
- R9: `load_done` is a single-cycle pulse. It occurs on the cycle right after the final shift cycle.
- R10: With `halt_n` = 0, a load is a plain run of back-to-back shifts, whatever the control bits hold.
- R11: After reset all outputs are 0 and the control register is cleared. A load started without reprogramming therefore has no stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running decompressor clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_ctrl | input | 1 | Shift `ctrl_bit` into the segment control register |
| ctrl_bit | input | 1 | Serial control bit, LSB first |
| start | input | 1 | Pattern start strobe |
| seg_len | input | LEN_W | Shifts per segment (at least 1) |
| chain_len | input | LEN_W+clog2(NSEG) | Longest chain length, at most NSEG×seg_len |
| halt_n | input | N_W | Stall cycles inserted before each shift of a marked segment |
| shift_en | output | 1 | One-cycle scan shift enable |
| decomp_adv | output | 1 | Decompressor advance, high for every load cycle |
| pad_shift | output | 1 | Current shift is a padding shift |
| load_done | output | 1 | Pulse one cycle after the final shift |

## Verification
The checker assumes a few things about the inputs: `seg_len`, `chain_len` and `halt_n` hold steady from the start strobe to the done pulse, `seg_len` is nonzero, and `chain_len` does not exceed NSEG×`seg_len`. Its cycle-count and stall-length properties are only valid under those conditions. The bench keeps to them by setting these inputs only while the block is idle, before each strobe. Control-register loading is always completed before the strobe. Disturbing pulses on `load_ctrl` and `start` are sent only in the middle of a running load.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  typedef enum logic [1:0] {
    DSC_IDLE = 2'd0,
    DSC_RUN  = 2'd1,
    DSC_DONE = 2'd2
  } dsc_state_e;

  // number of shift cycles in one load
  function automatic int unsigned load_shifts(input int unsigned nseg,
                                              input int unsigned seg_len);
    return nseg * seg_len;
  endfunction

  // full length of one load in cycles, stalls included
  function automatic int unsigned load_cycles(input int unsigned nseg,
                                              input int unsigned seg_len,
                                              input int unsigned halt_n,
                                              input int unsigned marked);
    return load_shifts(nseg, seg_len) + halt_n * seg_len * marked;
  endfunction

endpackage

// File: rtl/dsc_ctrl_reg.sv
module dsc_ctrl_reg #(
  parameter int NSEG = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_en,
  input  logic            bit_in,
  output logic [NSEG-1:0] ctrl_q
);

  // serial fill, LSB first: newest bit enters at the top
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (load_en) begin
      ctrl_q <= {bit_in, ctrl_q[NSEG-1:1]};
    end
  end

endmodule

// File: rtl/dsc_seg_tracker.sv
module dsc_seg_tracker #(
  parameter int NSEG    = 4,
  parameter int LEN_W   = 6,
  parameter int SEG_W   = 2,
  parameter int CHAIN_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               step,
  input  logic [LEN_W-1:0]   seg_len,
  output logic [SEG_W-1:0]   seg_idx,
  output logic [CHAIN_W-1:0] shift_num,
  output logic               last_shift
);

  localparam logic [SEG_W-1:0] TOP_SEG = SEG_W'(NSEG - 1);

  logic [LEN_W-1:0] pos_q;
  logic             seg_end;

  assign seg_end    = (pos_q == seg_len - 1'b1);
  assign last_shift = seg_end && (seg_idx == '0);

  // walk segments from the output end (highest index) toward the inputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q     <= '0;
      seg_idx   <= TOP_SEG;
      shift_num <= '0;
    end else if (clear) begin
      pos_q     <= '0;
      seg_idx   <= TOP_SEG;
      shift_num <= '0;
    end else if (step) begin
      shift_num <= shift_num + 1'b1;
      if (seg_end) begin
        pos_q <= '0;
        if (seg_idx != '0) begin
          seg_idx <= seg_idx - 1'b1;
        end
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/dsc_halt_ctr.sv
module dsc_halt_ctr #(
  parameter int N_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           active,
  input  logic           seg_sel,
  input  logic [N_W-1:0] halt_n,
  output logic           halt_fire
);

  logic [N_W-1:0] cnt_q;

  assign halt_fire = active && seg_sel && (cnt_q < halt_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (active && halt_fire) begin
      cnt_q <= cnt_q + 1'b1;
    end else begin
      cnt_q <= '0;
    end
  end

endmodule

// File: rtl/dyn_shift_ctrl.sv
module dyn_shift_ctrl #(
  parameter int NSEG  = 4,
  parameter int LEN_W = 6,
  parameter int N_W   = 4,
  localparam int SEG_W   = (NSEG > 1) ? $clog2(NSEG) : 1,
  localparam int CHAIN_W = LEN_W + SEG_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_ctrl,
  input  logic               ctrl_bit,
  input  logic               start,
  input  logic [LEN_W-1:0]   seg_len,
  input  logic [CHAIN_W-1:0] chain_len,
  input  logic [N_W-1:0]     halt_n,
  output logic               shift_en,
  output logic               decomp_adv,
  output logic               pad_shift,
  output logic               load_done
);

  import dsc_pkg::*;

  dsc_state_e          state_q;
  logic                run;
  logic                idle;
  logic                start_ok;
  logic [NSEG-1:0]     ctrl_q;
  logic [SEG_W-1:0]    seg_idx;
  logic [CHAIN_W-1:0]  shift_num;
  logic                last_shift;
  logic                seg_sel;
  logic                halt_fire;
  logic                shift_fire;
  logic [CHAIN_W-1:0]  pad_q;

  assign idle     = (state_q == DSC_IDLE);
  assign run      = (state_q == DSC_RUN);
  assign start_ok = idle && start;

  dsc_ctrl_reg #(.NSEG(NSEG)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_en(idle && load_ctrl),
    .bit_in (ctrl_bit),
    .ctrl_q (ctrl_q)
  );

  dsc_seg_tracker #(
    .NSEG(NSEG), .LEN_W(LEN_W), .SEG_W(SEG_W), .CHAIN_W(CHAIN_W)
  ) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start_ok),
    .step      (shift_fire),
    .seg_len   (seg_len),
    .seg_idx   (seg_idx),
    .shift_num (shift_num),
    .last_shift(last_shift)
  );

  assign seg_sel = ctrl_q[seg_idx];

  dsc_halt_ctr #(.N_W(N_W)) u_halt (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (run),
    .seg_sel  (seg_sel),
    .halt_n   (halt_n),
    .halt_fire(halt_fire)
  );

  assign shift_fire = run && !halt_fire;

  // padding count latched at the strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_q <= '0;
    end else if (start_ok) begin
      pad_q <= CHAIN_W'(load_shifts(NSEG, 32'(seg_len))) - chain_len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DSC_IDLE;
    end else begin
      unique case (state_q)
        DSC_IDLE: if (start)                    state_q <= DSC_RUN;
        DSC_RUN:  if (shift_fire && last_shift) state_q <= DSC_DONE;
        DSC_DONE:                               state_q <= DSC_IDLE;
        default:                                state_q <= DSC_IDLE;
      endcase
    end
  end

  assign shift_en   = shift_fire;
  assign decomp_adv = run;
  assign pad_shift  = shift_fire && (shift_num < pad_q);
  assign load_done  = (state_q == DSC_DONE);

endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
  parameter int NSEG  = 4,
  parameter int LEN_W = 6,
  parameter int N_W   = 4,
  parameter int SEG_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LEN_W-1:0] seg_len,
  input logic [N_W-1:0]   halt_n,
  input logic             shift_en,
  input logic             decomp_adv,
  input logic             pad_shift,
  input logic             load_done,
  input logic             run,
  input logic [NSEG-1:0]  ctrl_q,
  input logic [SEG_W-1:0] seg_idx
);

  import dsc_pkg::*;

  logic [31:0] cyc_q;
  logic [31:0] stall_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q   <= '0;
      stall_q <= '0;
    end else begin
      cyc_q   <= run ? cyc_q + 1 : '0;
      stall_q <= (decomp_adv && !shift_en) ? stall_q + 1 : '0;
    end
  end

  p_ctrl_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(ctrl_q));

  p_stall_marked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (decomp_adv && !shift_en) |-> ctrl_q[seg_idx]);

  p_stall_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stall_q <= 32'(halt_n));

  p_shift_adv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |-> decomp_adv);

  p_done_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> !decomp_adv);

  p_load_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> (cyc_q == load_cycles(NSEG, 32'(seg_len), 32'(halt_n),
                                        32'($countones(ctrl_q)))));

  p_pad_on_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pad_shift |-> shift_en);

  p_done_after_shift_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> $past(shift_en));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> !load_done);

  p_no_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((halt_n == '0) && decomp_adv) |-> shift_en);

endmodule

bind dyn_shift_ctrl dsc_checker #(
  .NSEG(NSEG), .LEN_W(LEN_W), .N_W(N_W), .SEG_W(SEG_W)
) u_dsc_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .seg_len   (seg_len),
  .halt_n    (halt_n),
  .shift_en  (shift_en),
  .decomp_adv(decomp_adv),
  .pad_shift (pad_shift),
  .load_done (load_done),
  .run       (run),
  .ctrl_q    (ctrl_q),
  .seg_idx   (seg_idx)
);

// File: tb/test_dyn_shift_ctrl.sv
module test_dyn_shift_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NSEG  = 4;
  localparam int LEN_W = 6;
  localparam int N_W   = 4;
  localparam int CHAIN_W = LEN_W + 2;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               load_ctrl = 1'b0;
  logic               ctrl_bit = 1'b0;
  logic               start = 1'b0;
  logic [LEN_W-1:0]   seg_len = 6'd3;
  logic [CHAIN_W-1:0] chain_len = 8'd12;
  logic [N_W-1:0]     halt_n = '0;
  logic               shift_en, decomp_adv, pad_shift, load_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  dyn_shift_ctrl #(.NSEG(NSEG), .LEN_W(LEN_W), .N_W(N_W)) i_dyn_shift_ctrl (
    .clk(clk), .rst_n(rst_n), .load_ctrl(load_ctrl), .ctrl_bit(ctrl_bit),
    .start(start), .seg_len(seg_len), .chain_len(chain_len), .halt_n(halt_n),
    .shift_en(shift_en), .decomp_adv(decomp_adv), .pad_shift(pad_shift),
    .load_done(load_done)
  );

  typedef struct {
    logic  sh;
    logic  adv;
    logic  pad;
    logic  done;
    string req;
  } exp_t;

  exp_t        exp_q[$];
  int          n_vec  = 0;
  int          n_fail = 0;
  int          seen_shifts = 0;
  bit          go = 1'b0;
  bit          finished = 1'b0;
  logic [NSEG-1:0] model_ctrl = '0;

  task automatic check(input string req, input logic act, input logic expv,
                       input string what);
    n_vec++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, expv, $time);
    end
  endtask

  // monitor: pops expected cycle items and compares
  always @(negedge clk) begin
    if (go && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      if (shift_en === 1'b1) seen_shifts++;
      check(e.req, shift_en,   e.sh,   "shift_en");
      check(e.req, decomp_adv, e.adv,  "decomp_adv");
      check(e.req, pad_shift,  e.pad,  "pad_shift");
      check(e.req, load_done,  e.done, "load_done");
    end
  end

  function automatic exp_t mk(input logic sh, input logic adv, input logic pad,
                              input logic done, input string req);
    exp_t e;
    e.sh = sh; e.adv = adv; e.pad = pad; e.done = done; e.req = req;
    return e;
  endfunction

  // R1: serial fill, LSB first
  task automatic load_bits(input logic [NSEG-1:0] bits);
    for (int i = 0; i < NSEG; i++) begin
      @(negedge clk);
      load_ctrl = 1'b1;
      ctrl_bit  = bits[i];
    end
    @(negedge clk);
    load_ctrl = 1'b0;
    ctrl_bit  = 1'b0;
    model_ctrl = bits;
  endtask

  // driver: pushes the expected cycle sequence, then runs one load
  task automatic run_load(input bit do_load, input logic [NSEG-1:0] bits,
                          input int len, input int chain, input int n,
                          input bit disturb);
    int pad;
    if (do_load) load_bits(bits);
    @(negedge clk);
    seg_len   = LEN_W'(len);
    chain_len = CHAIN_W'(chain);
    halt_n    = N_W'(n);
    pad = NSEG * len - chain;
    for (int k = 0; k < NSEG * len; k++) begin
      int seg;
      seg = NSEG - 1 - k / len;  // R6: output-end segment first
      if (model_ctrl[seg]) begin
        for (int h = 0; h < n; h++) exp_q.push_back(mk(1'b0, 1'b1, 1'b0, 1'b0, "R4"));
      end
      if (k < pad) exp_q.push_back(mk(1'b1, 1'b1, 1'b1, 1'b0, "R8"));
      else if (model_ctrl[seg] && n > 0) exp_q.push_back(mk(1'b1, 1'b1, 1'b0, 1'b0, "R4"));
      else exp_q.push_back(mk(1'b1, 1'b1, 1'b0, 1'b0, "R3"));
    end
    exp_q.push_back(mk(1'b0, 1'b0, 1'b0, 1'b1, "R9"));
    exp_q.push_back(mk(1'b0, 1'b0, 1'b0, 1'b0, "R5"));
    exp_q.push_back(mk(1'b0, 1'b0, 1'b0, 1'b0, "R5"));
    seen_shifts = 0;
    start = 1'b1;
    @(posedge clk);
    go = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      // R2: strobe and control load while running must be ignored
      @(negedge clk);
      @(negedge clk);
      load_ctrl = 1'b1; ctrl_bit = ~model_ctrl[0]; start = 1'b1;
      @(negedge clk);
      @(negedge clk);
      load_ctrl = 1'b0; ctrl_bit = 1'b0; start = 1'b0;
    end
    wait (exp_q.size() == 0);
    @(posedge clk);
    go = 1'b0;
    // R7: shift count of the load
    n_vec++;
    if (seen_shifts != NSEG * len) begin
      n_fail++;
      $display("FAIL R7 shift count actual=%0d expected=%0d", seen_shifts, NSEG * len);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: outputs quiet in and after reset
    check("R11", shift_en,   1'b0, "shift_en");
    check("R11", decomp_adv, 1'b0, "decomp_adv");
    check("R11", load_done,  1'b0, "load_done");
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", pad_shift, 1'b0, "pad_shift");
    // R11: cleared register -> no stalls even with halt_n set
    run_load(1'b0, '0, 3, 12, 5, 1'b0);
    // R1 R4 R6: alternating marked segments
    run_load(1'b1, 4'b0101, 3, 12, 2, 1'b0);
    // R8: padding of output-end segment, only top segment marked
    run_load(1'b1, 4'b1000, 3, 10, 3, 1'b0);
    // R10: zero stall count with every segment marked
    run_load(1'b1, 4'b1111, 3, 12, 0, 1'b0);
    // single-shift segments, all marked
    run_load(1'b1, 4'b1111, 1, 3, 1, 1'b0);
    // R7: longest stall, one marked segment, padding
    run_load(1'b1, 4'b0010, 5, 17, 15, 1'b0);
    // R2: disturbance during a running load
    run_load(1'b1, 4'b0110, 4, 16, 2, 1'b1);
    // R2: register kept, reuse without reload
    run_load(1'b0, '0, 4, 16, 2, 1'b0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule